// File: doc/BRIEF.md
# Register File Token Control

This block is the control-path companion of one register file inside a coarse-grained reconfigurable array. Data never passes through it. It sees one-bit tokens, and each token announces that a valid datum will appear on the matching datapath link in the following cycle. Every token carries a staging-predicate bit with it.

On the write side, each write port has a multiplexer with several inputs. The block turns the position of an arriving token into that multiplexer's select value and a write enable, one cycle later. No source field is stored for the multiplexer. Tokens end at the register file and are not passed on.

On the read side, each read port starts fresh tokens. It does so only in a cycle where its one-bit emit flag from configuration is set. The fresh tokens go to at most two consumer links, and two destination fields name those links. A field that holds the all-ones code names no link.

Top module: `rf_token_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises with no tokens driven, every write enable, select, predicate and conflict output is 0.
- R2: If exactly one token arrives on input k of write port w in cycle t, then in cycle t+1 wr_en_o[w] is 1 and wr_sel_o for port w equals k.
- R3: If no token arrives on write port w in cycle t, then in cycle t+1 wr_en_o[w], its select and wr_pred_o[w] are all 0.
- R4: If two or more tokens arrive on write port w in one cycle, then in the next cycle wr_en_o[w] is 1 and the select is the lowest-numbered input that carried a token.
- R5: If two or more tokens arrive on write port w in one cycle, wr_conflict_o[w] is 1 from the next cycle on and stays 1 until reset.
- R6: In the cycle after a write port receives tokens, wr_pred_o[w] equals the staging-predicate bit of the selected input.
- R7: A read port whose emit bit is 0 drives no token on any of its links, whatever its destination fields hold. The sender is combinational, so this holds in the same cycle.
- R8: A read port whose emit bit is 1 drives a token, in the same cycle, on each link l (0 <= l < NUM_LINKS) named by either of its two destination fields. A field code of NUM_LINKS or more, including the all-ones code, names no link, so at most two links carry a token.
- R9: A link that carries a token has its outgoing predicate equal to the predicate input of its read port. A link that carries no token has predicate 0.
- R10: Tokens that arrive on write ports never appear on any outgoing token link. With every emit bit 0, all outgoing token and predicate bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_in_v_i | input | NUM_WR*NUM_IN | Incoming tokens. Bit w*NUM_IN+k is input k of write port w |
| tok_in_p_i | input | NUM_WR*NUM_IN | Staging predicate carried with each incoming token, same packing |
| wr_en_o | output | NUM_WR | Write enable for each write port |
| wr_sel_o | output | NUM_WR*SEL_W | Mux select. Field w is bits [w*SEL_W +: SEL_W] |
| wr_pred_o | output | NUM_WR | Staging predicate of the selected token for each write port |
| wr_conflict_o | output | NUM_WR | Sticky flag: more than one token arrived on the port in one cycle |
| rd_emit_i | input | NUM_RD | Per-cycle emit bit for each read port |
| rd_pred_i | input | NUM_RD | Staging predicate for each read port's new tokens |
| rd_dest_i | input | NUM_RD*2*DEST_W | Destination fields. Field d of port r is bits [(r*2+d)*DEST_W +: DEST_W] |
| tok_out_v_o | output | NUM_RD*NUM_LINKS | Outgoing tokens. Bit r*NUM_LINKS+l is link l of read port r |
| tok_out_p_o | output | NUM_RD*NUM_LINKS | Predicate carried with each outgoing token |

## Verification
The bench builds the block with two write ports of five inputs each, three read ports and six links per port. With five inputs, the select is three bits wide and its top codes can never be valid. With six links, the 3-bit destination field has two codes that name no link: the out-of-range code 6 and the reserved all-ones code 7. Both must be ignored.

Directed cycles cover:
- a single token on every input in turn;
- several tokens on one port;
- duplicate destination fields;
- write-side tokens with every emit bit cleared.

A reset in mid-run shows that the conflict flags are cleared. Random cycles then mix all these cases.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam int unsigned NUM_DEST = 2;

  function automatic int unsigned width_min1(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rft_wr_receiver.sv
module rft_wr_receiver #(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned SEL_W  = rft_pkg::width_min1(NUM_IN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] tok_v_i,
  input  logic [NUM_IN-1:0] tok_p_i,
  output logic              wr_en_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic              wr_pred_o,
  output logic              conflict_o
);
  logic             any_tok, multi_tok, pred_d;
  logic [SEL_W-1:0] sel_d;

  // lowest-numbered token wins
  always_comb begin
    sel_d  = '0;
    pred_d = 1'b0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (tok_v_i[i]) begin
        sel_d  = SEL_W'(i);
        pred_d = tok_p_i[i];
      end
    end
  end

  assign any_tok   = |tok_v_i;
  assign multi_tok = |(tok_v_i & (tok_v_i - NUM_IN'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o    <= 1'b0;
      wr_sel_o   <= '0;
      wr_pred_o  <= 1'b0;
      conflict_o <= 1'b0;
    end else begin
      wr_en_o    <= any_tok;
      wr_sel_o   <= sel_d;
      wr_pred_o  <= pred_d;
      conflict_o <= conflict_o | multi_tok;
    end
  end

  // R2
  token_then_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_tok |=> wr_en_o);
  // R3
  idle_then_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_tok |=> (!wr_en_o && wr_sel_o == '0 && !wr_pred_o));
  // R4
  sel_hits_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_tok |=> (($past(tok_v_i) & (NUM_IN'(1) << wr_sel_o)) != '0));
  // R5
  conflict_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> conflict_o);
endmodule

// File: rtl/rft_rd_sender.sv
module rft_rd_sender #(
  parameter int unsigned NUM_LINKS = 4,
  parameter int unsigned DEST_W    = $clog2(NUM_LINKS + 1),
  parameter int unsigned NUM_DEST  = rft_pkg::NUM_DEST
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       emit_i,
  input  logic                       pred_i,
  input  logic [NUM_DEST*DEST_W-1:0] dest_i,
  output logic [NUM_LINKS-1:0]       tok_v_o,
  output logic [NUM_LINKS-1:0]       tok_p_o
);
  logic [NUM_LINKS-1:0] hit;

  // codes at or above NUM_LINKS (incl. all-ones) match nothing
  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    always_comb begin
      hit[l] = 1'b0;
      for (int d = 0; d < NUM_DEST; d++)
        if (dest_i[d*DEST_W +: DEST_W] == DEST_W'(l)) hit[l] = 1'b1;
    end
  end

  assign tok_v_o = emit_i ? hit : '0;
  assign tok_p_o = (emit_i && pred_i) ? hit : '0;

  // R7
  no_emit_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |-> (tok_v_o == '0));
  // R8
  fanout_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tok_v_o) <= NUM_DEST);
  // R9
  pred_on_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_p_o & ~tok_v_o) == '0);
endmodule

// File: rtl/rf_token_ctrl.sv
module rf_token_ctrl #(
  parameter int unsigned NUM_WR    = 2,
  parameter int unsigned NUM_IN    = 4,
  parameter int unsigned NUM_RD    = 3,
  parameter int unsigned NUM_LINKS = 4,
  localparam int unsigned SEL_W    = rft_pkg::width_min1(NUM_IN),
  localparam int unsigned DEST_W   = $clog2(NUM_LINKS + 1),
  localparam int unsigned NDST     = rft_pkg::NUM_DEST
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WR*NUM_IN-1:0]      tok_in_v_i,
  input  logic [NUM_WR*NUM_IN-1:0]      tok_in_p_i,
  output logic [NUM_WR-1:0]             wr_en_o,
  output logic [NUM_WR*SEL_W-1:0]       wr_sel_o,
  output logic [NUM_WR-1:0]             wr_pred_o,
  output logic [NUM_WR-1:0]             wr_conflict_o,
  input  logic [NUM_RD-1:0]             rd_emit_i,
  input  logic [NUM_RD-1:0]             rd_pred_i,
  input  logic [NUM_RD*NDST*DEST_W-1:0] rd_dest_i,
  output logic [NUM_RD*NUM_LINKS-1:0]   tok_out_v_o,
  output logic [NUM_RD*NUM_LINKS-1:0]   tok_out_p_o
);
  for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
    rft_wr_receiver #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_rx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tok_v_i    (tok_in_v_i[w*NUM_IN +: NUM_IN]),
      .tok_p_i    (tok_in_p_i[w*NUM_IN +: NUM_IN]),
      .wr_en_o    (wr_en_o[w]),
      .wr_sel_o   (wr_sel_o[w*SEL_W +: SEL_W]),
      .wr_pred_o  (wr_pred_o[w]),
      .conflict_o (wr_conflict_o[w])
    );
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    rft_rd_sender #(.NUM_LINKS(NUM_LINKS), .DEST_W(DEST_W), .NUM_DEST(NDST)) u_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .emit_i  (rd_emit_i[r]),
      .pred_i  (rd_pred_i[r]),
      .dest_i  (rd_dest_i[r*NDST*DEST_W +: NDST*DEST_W]),
      .tok_v_o (tok_out_v_o[r*NUM_LINKS +: NUM_LINKS]),
      .tok_p_o (tok_out_p_o[r*NUM_LINKS +: NUM_LINKS])
    );
  end

  // R10
  write_tokens_end_here_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_emit_i == '0) |-> (tok_out_v_o == '0 && tok_out_p_o == '0));
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (wr_en_o == '0 && wr_conflict_o == '0));
endmodule

// File: tb/rf_token_ctrl_tb.sv
module rf_token_ctrl_tb_top;
  localparam int NUM_WR = 2, NUM_IN = 5, NUM_RD = 3, NUM_LINKS = 6;
  localparam int SEL_W = 3, DEST_W = 3;

  logic clk = 0, rst_ni = 0;
  logic [NUM_WR*NUM_IN-1:0]     tin_v = '0, tin_p = '0;
  logic [NUM_RD-1:0]            emit = '0, rpred = '0;
  logic [NUM_RD*2*DEST_W-1:0]   dest = '0;
  logic [NUM_WR-1:0]            wr_en, wr_pred, wr_conf;
  logic [NUM_WR*SEL_W-1:0]      wr_sel;
  logic [NUM_RD*NUM_LINKS-1:0]  tout_v, tout_p;

  int checks = 0, errors = 0;
  int exp_en[NUM_WR], exp_sel[NUM_WR], exp_pred[NUM_WR], exp_conf[NUM_WR], exp_multi[NUM_WR];

  always #5 clk = ~clk;

  rf_token_ctrl #(.NUM_WR(NUM_WR), .NUM_IN(NUM_IN), .NUM_RD(NUM_RD), .NUM_LINKS(NUM_LINKS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tok_in_v_i(tin_v), .tok_in_p_i(tin_p),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_pred_o(wr_pred), .wr_conflict_o(wr_conf),
    .rd_emit_i(emit), .rd_pred_i(rpred), .rd_dest_i(dest),
    .tok_out_v_o(tout_v), .tok_out_p_o(tout_p));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic clear_model();
    for (int w = 0; w < NUM_WR; w++) begin
      exp_en[w] = 0; exp_sel[w] = 0; exp_pred[w] = 0; exp_conf[w] = 0; exp_multi[w] = 0;
    end
  endtask

  task automatic check_writes();
    for (int w = 0; w < NUM_WR; w++) begin
      if (exp_en[w] != 0) begin
        chk(exp_multi[w] != 0 ? "R4" : "R2", $sformatf("en[%0d]", w), int'(wr_en[w]), 1);
        chk(exp_multi[w] != 0 ? "R4" : "R2", $sformatf("sel[%0d]", w), int'(wr_sel[w*SEL_W +: SEL_W]), exp_sel[w]);
        chk("R6", $sformatf("pred[%0d]", w), int'(wr_pred[w]), exp_pred[w]);
      end else begin
        chk("R3", $sformatf("en[%0d]", w), int'(wr_en[w]), 0);
        chk("R3", $sformatf("sel[%0d]", w), int'(wr_sel[w*SEL_W +: SEL_W]), 0);
        chk("R3", $sformatf("pred[%0d]", w), int'(wr_pred[w]), 0);
      end
      chk("R5", $sformatf("conflict[%0d]", w), int'(wr_conf[w]), exp_conf[w]);
    end
  endtask

  task automatic model_writes();
    for (int w = 0; w < NUM_WR; w++) begin
      int cnt = 0;
      exp_en[w] = 0; exp_sel[w] = 0; exp_pred[w] = 0;
      for (int k = NUM_IN - 1; k >= 0; k--) begin
        if (tin_v[w*NUM_IN + k]) begin
          cnt++;
          exp_en[w] = 1; exp_sel[w] = k; exp_pred[w] = int'(tin_p[w*NUM_IN + k]);
        end
      end
      exp_multi[w] = (cnt > 1) ? 1 : 0;
      if (cnt > 1) exp_conf[w] = 1;
    end
  endtask

  task automatic check_senders();
    for (int r = 0; r < NUM_RD; r++) begin
      int d0 = int'(dest[(r*2)*DEST_W +: DEST_W]);
      int d1 = int'(dest[(r*2+1)*DEST_W +: DEST_W]);
      for (int l = 0; l < NUM_LINKS; l++) begin
        int ev = (emit[r] && (d0 == l || d1 == l)) ? 1 : 0;
        int ep = (ev != 0 && rpred[r]) ? 1 : 0;
        string tag = (emit == '0) ? "R10" : (emit[r] ? "R8" : "R7");
        chk(tag, $sformatf("tok[%0d][%0d]", r, l), int'(tout_v[r*NUM_LINKS + l]), ev);
        chk((emit == '0) ? "R10" : "R9", $sformatf("ptok[%0d][%0d]", r, l), int'(tout_p[r*NUM_LINKS + l]), ep);
      end
    end
  endtask

  task automatic step(input logic [NUM_WR*NUM_IN-1:0] v, input logic [NUM_WR*NUM_IN-1:0] p,
                      input logic [NUM_RD-1:0] e, input logic [NUM_RD-1:0] rp,
                      input logic [NUM_RD*2*DEST_W-1:0] dst);
    @(negedge clk);
    check_writes();
    tin_v = v; tin_p = p; emit = e; rpred = rp; dest = dst;
    model_writes();
    #1;
    check_senders();
  endtask

  task automatic do_reset();
    @(negedge clk);
    tin_v = '0; tin_p = '0; emit = '0; rpred = '0; dest = '0;
    rst_ni = 0;
    #2;
    for (int w = 0; w < NUM_WR; w++) begin
      chk("R1", "en in reset", int'(wr_en[w]), 0);
      chk("R1", "conflict in reset", int'(wr_conf[w]), 0);
      chk("R1", "pred in reset", int'(wr_pred[w]), 0);
    end
    chk("R1", "sel in reset", int'(wr_sel), 0);
    clear_model();
    @(negedge clk);
    rst_ni = 1;
  endtask

  function automatic logic [NUM_RD*2*DEST_W-1:0] dests(input int a0, input int a1, input int b0,
                                                       input int b1, input int c0, input int c1);
    logic [NUM_RD*2*DEST_W-1:0] f;
    f[0*DEST_W +: DEST_W] = DEST_W'(a0); f[1*DEST_W +: DEST_W] = DEST_W'(a1);
    f[2*DEST_W +: DEST_W] = DEST_W'(b0); f[3*DEST_W +: DEST_W] = DEST_W'(b1);
    f[4*DEST_W +: DEST_W] = DEST_W'(c0); f[5*DEST_W +: DEST_W] = DEST_W'(c1);
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (2) @(negedge clk);
    do_reset();
    // R1 first cycle after reset, idle
    step('0, '0, '0, '0, '0);
    // R2 single token on each input of each port, R6 predicate alternates
    for (int w = 0; w < NUM_WR; w++)
      for (int k = 0; k < NUM_IN; k++)
        step((NUM_WR*NUM_IN)'(1) << (w*NUM_IN + k), (NUM_WR*NUM_IN)'(k % 2) << (w*NUM_IN + k),
             '0, '0, '0);
    step('0, '0, '0, '0, '0);
    // R4 R5 multiple tokens on port 0, lowest is input 2
    step(10'b00000_11100, 10'b00000_00100, '0, '0, '0);
    step('0, '0, '0, '0, '0);
    step(10'b00001_00000, '0, '0, '0, '0);
    // R10 write tokens with dests programmed but no emit
    step(10'b10101_01010, 10'b11111_11111, '0, 3'b111, dests(0, 1, 2, 3, 4, 5));
    // R7 R8 R9 emit patterns, unused codes 6 and 7, duplicates
    step('0, '0, 3'b001, 3'b001, dests(0, 5, 7, 7, 1, 2));
    step('0, '0, 3'b111, 3'b010, dests(7, 7, 6, 3, 4, 4));
    step('0, '0, 3'b110, 3'b111, dests(2, 3, 6, 7, 0, 5));
    step('0, '0, 3'b101, 3'b100, dests(1, 1, 0, 2, 7, 3));
    step('0, '0, '0, '0, '0);
    // R5 cleared only by reset
    do_reset();
    step('0, '0, '0, '0, '0);
    for (int n = 0; n < 400; n++) begin
      logic [NUM_WR*NUM_IN-1:0] v = (NUM_WR*NUM_IN)'($urandom);
      if (n % 3 == 0) v = v & (NUM_WR*NUM_IN)'($urandom);
      step(v, (NUM_WR*NUM_IN)'($urandom), NUM_RD'($urandom), NUM_RD'($urandom),
           (NUM_RD*2*DEST_W)'($urandom));
    end
    step('0, '0, '0, '0, '0);
    step('0, '0, '0, '0, '0);
    finish_run();
  end
endmodule